// File: doc/BRIEF.md
# Shadow-Reloaded Compare-Clear Timer

This block is a 14-bit counter whose period comes from a compare-clear value. Software never writes that value directly. It writes a buffer instead, and the buffer is copied into the active compare register only when the counter passes through zero. A new period therefore always starts on a clean cycle boundary. The counter advances once per `count_en` strobe. When the count reaches the active compare value, one of two things happens, chosen by a control bit. In sawtooth mode the counter restarts from zero. In triangle mode the counter turns round and counts back down to zero, then climbs again.

The zero-point copy has two controls. One bit enables the copy. A second bit decides whether the copy still takes place while the zero-detect interrupt is masked. An active compare value of zero turns matching off, and the counter then wraps freely over its full range. The block gives a one-cycle match pulse and a one-cycle zero pulse. The zero pulse sets a sticky flag that software clears by writing 1. All of this is reached through a small byte-wide write port.

Top module: `shadow_cmp_timer`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: `count`, `cmp_active`, `count_down`, both pulses, `zero_flag` and `zero_irq`.
- R2: Write-port map:
  - Address 0 loads buffer bits 7..0.
  - Address 1 loads buffer bits 13..8 from `wr_data[5:0]`. Data bits 7..6 are dropped.
  - Address 2 is control: bit 0 selects triangle mode, bit 1 enables the transfer, bit 2 masks the zero interrupt, bit 3 allows the transfer while masked.
  - Address 3 is status: writing 1 to bit 0 clears the zero flag.
- R3: `count` and the count direction change only on a cycle where `count_en` is high.
- R4: In sawtooth mode, with active value V > 0, the counter runs 0..V and then returns to 0. The period is V+1 strobes.
- R5: In triangle mode, with V > 0, the counter rises to V and falls back to 0. The period is 2·V strobes and the count never exceeds V.
- R6: The buffer is copied into `cmp_active` only on a strobe taken while `count` is 0. A buffer write at any other time leaves `cmp_active`, and therefore the current period, unchanged.
- R7: With the transfer-enable bit at 0, no copy ever occurs.
- R8: While the zero interrupt is masked, the copy occurs only if the transfer-while-masked bit is 1.
- R9: With `cmp_active` equal to 0, no match is raised and the counter wraps after 16384 strobes.
- R10: `match_pulse` is high for the one cycle after a matching strobe. `zero_pulse` is high for the one cycle after a strobe taken at count 0. In sawtooth mode the zero pulse follows the match pulse by exactly one cycle.
- R11: A zero pulse sets `zero_flag`. A set in the same cycle as a clear takes priority over the clear. `zero_irq` equals the flag gated by the mask bit being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_en | input | 1 | Count strobe; one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| count | output | 14 | Current counter value |
| cmp_active | output | 14 | Active compare-clear value |
| count_down | output | 1 | High while counting down (triangle mode) |
| match_pulse | output | 1 | One-cycle pulse after a compare match |
| zero_pulse | output | 1 | One-cycle pulse after a strobe at count zero |
| zero_flag | output | 1 | Sticky zero-detect flag |
| zero_irq | output | 1 | Zero-detect interrupt (flag and not masked) |

## Verification
The assertions check the per-cycle rules on every cycle:
- the count holds without a strobe;
- the count stays within the active value;
- the turnaround from 1 to 0 restores up-counting;
- `cmp_active` changes only through a permitted zero-point copy;
- a zero compare value never produces a match;
- the zero flag rises after every zero strobe.

Some behaviours only show over whole periods, so only the bench scenarios can demonstrate them. These are:
- the period lengths V+1 and 2·V;
- the full-range wrap;
- a mid-period buffer write that shifts the period only after the next zero;
- the effect of the enable and mask qualifiers on the copy.

// File: rtl/shcmp_pkg.sv
// Shared definitions for the shadow-reloaded compare-clear timer.
// Assumes the register map: buffer byte lanes first, then control, then status.
package shcmp_pkg;

    // Bit positions inside the control byte.
    localparam int CTL_UPDOWN  = 0;
    localparam int CTL_XFER_EN = 1;
    localparam int CTL_IRQ_MSK = 2;
    localparam int CTL_XFER_MK = 3;

    // Bit position of the write-1-to-clear flag bit in the status byte.
    localparam int STAT_CLR    = 0;

    typedef struct packed {
        logic xfer_masked;  // allow copy while zero irq is masked
        logic irq_mask;     // mask the zero-detect interrupt
        logic xfer_en;      // enable buffer-to-active copy at zero
        logic updown;       // 1: reverse on match, 0: clear on match
    } ctrl_t;

endpackage

// File: rtl/shcmp_regs.sv
// Write-port register file: compare buffer (byte lanes), control byte, and
// the sticky zero-detect flag. Assumes one write per cycle, no read path.
module shcmp_regs
    import shcmp_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              zero_tick,
    output logic [CNT_W-1:0]  buf_val,
    output ctrl_t             ctrl,
    output logic              zero_flag
);

    localparam int NLANE     = (CNT_W + DATA_W - 1) / DATA_W;
    localparam int ADDR_CTL  = NLANE;
    localparam int ADDR_STAT = NLANE + 1;

    ctrl_t ctrl_q;
    logic  flag_q;
    logic  ctl_wr;
    logic  stat_clr;

    assign ctl_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_CTL));
    assign stat_clr = wr_en && (wr_addr == ADDR_W'(ADDR_STAT)) && wr_data[STAT_CLR];

    // One storage lane per byte of the compare buffer; the last lane may be narrower.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LO = g * DATA_W;
        localparam int LW = ((CNT_W - LO) < DATA_W) ? (CNT_W - LO) : DATA_W;
        logic [LW-1:0] lane_q;

        // Lane storage: load the low LW data bits when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                lane_q <= wr_data[LW-1:0];
            end
        end

        assign buf_val[LO +: LW] = lane_q;
    end

    // Control byte: capture the mode and transfer qualifiers on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctl_wr) begin
            ctrl_q.updown      <= wr_data[CTL_UPDOWN];
            ctrl_q.xfer_en     <= wr_data[CTL_XFER_EN];
            ctrl_q.irq_mask    <= wr_data[CTL_IRQ_MSK];
            ctrl_q.xfer_masked <= wr_data[CTL_XFER_MK];
        end
    end

    // Sticky zero flag: set by a zero strobe, cleared by write-1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (zero_tick) begin
            flag_q <= 1'b1;
        end else if (stat_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign ctrl      = ctrl_q;
    assign zero_flag = flag_q;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctrl_q.updown == $past(wr_data[CTL_UPDOWN])) &&
                   (ctrl_q.xfer_en == $past(wr_data[CTL_XFER_EN]))); // R2

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        zero_tick |=> flag_q); // R11

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !zero_tick) |=> !flag_q); // R11

endmodule

// File: rtl/shcmp_counter.sv
// Up/down counter with compare-clear. Counts one step per count_en strobe.
// On a match with a nonzero compare value it either clears (sawtooth) or
// reverses to down-count (triangle); in triangle mode it turns back to up
// when it steps from 1 to 0. Assumes cmp changes only at count zero.
module shcmp_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             updown,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             zero_tick,
    output logic             match_pulse,
    output logic             zero_pulse
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             down_q;
    logic             hit;
    logic             match_q;
    logic             zero_q;

    // Match is live only while counting up against a nonzero compare value.
    assign hit       = (cmp != '0) && (cnt_q == cmp) && !down_q;
    assign zero_tick = count_en && (cnt_q == '0);

    // Count state: step, clear or reverse on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (count_en) begin
            if (down_q) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q <= ONE) begin
                    down_q <= 1'b0;
                end
            end else if (hit) begin
                if (!updown) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q  <= cnt_q - 1'b1;
                    down_q <= (cnt_q != ONE);
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Event pulses: one cycle after the strobe that caused them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            match_q <= count_en && hit;
            zero_q  <= zero_tick;
        end
    end

    assign cnt         = cnt_q;
    assign down        = down_q;
    assign match_pulse = match_q;
    assign zero_pulse  = zero_q;

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> $stable(cnt_q) && $stable(down_q)); // R3

    AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && hit && !updown) |=> (cnt_q == '0) && !down_q); // R4

    AST_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp != '0) |-> (cnt_q <= cmp)); // R5

    AST_TURN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && down_q && (cnt_q == ONE)) |=> (cnt_q == '0) && !down_q); // R5

    AST_NO_MATCH_ZERO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp == '0) |=> !match_q); // R9

    AST_ZERO_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |=> !zero_q); // R10

endmodule

// File: rtl/shcmp_shadow.sv
// Active compare register. Copies the buffer in only on a strobe taken at
// count zero, when the transfer is enabled and not blocked by the mask rule.
module shcmp_shadow
    import shcmp_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_tick,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] buf_val,
    output logic [CNT_W-1:0] cmp
);

    logic [CNT_W-1:0] cmp_q;
    logic             allow;
    logic             load;

    // Mask rule: a masked zero interrupt blocks the copy unless explicitly allowed.
    assign allow = ctrl.xfer_en && (!ctrl.irq_mask || ctrl.xfer_masked);
    assign load  = zero_tick && allow;

    // Active value: reload from the buffer at a permitted zero point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (load) begin
            cmp_q <= buf_val;
        end
    end

    assign cmp = cmp_q;

    AST_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_tick |=> $stable(cmp_q)); // R6

    AST_LOAD_TAKES_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cmp_q == $past(buf_val))); // R6

    AST_NO_COPY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.xfer_en |=> $stable(cmp_q)); // R7

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.irq_mask && !ctrl.xfer_masked) |=> $stable(cmp_q)); // R8

endmodule

// File: rtl/shadow_cmp_timer.sv
// Top level: compare-clear timer with a buffered period register.
// Ties the write-port registers, the active compare register and the
// counter together and derives the gated zero interrupt.
module shadow_cmp_timer
    import shcmp_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cmp_active,
    output logic              count_down,
    output logic              match_pulse,
    output logic              zero_pulse,
    output logic              zero_flag,
    output logic              zero_irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] buf_val;
    logic [CNT_W-1:0] cmp;
    logic             zero_tick;

    shcmp_regs #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .zero_tick(zero_tick),
        .buf_val  (buf_val),
        .ctrl     (ctrl),
        .zero_flag(zero_flag)
    );

    shcmp_shadow #(
        .CNT_W(CNT_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_tick(zero_tick),
        .ctrl     (ctrl),
        .buf_val  (buf_val),
        .cmp      (cmp)
    );

    shcmp_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (count_en),
        .updown     (ctrl.updown),
        .cmp        (cmp),
        .cnt        (count),
        .down       (count_down),
        .zero_tick  (zero_tick),
        .match_pulse(match_pulse),
        .zero_pulse (zero_pulse)
    );

    assign cmp_active = cmp;
    assign zero_irq   = zero_flag && !ctrl.irq_mask;

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |-> zero_flag); // R11

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && (cmp_active == '0) && !zero_flag && !count_down); // R1

endmodule

// File: tb/shadow_cmp_timer_bench.sv
// Scoreboard bench: the driver queues expected zero-to-zero periods; a
// monitor measures them from zero_pulse and compares in order.
module shadow_cmp_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [13:0] count;
    logic [13:0] cmp_active;
    logic        count_down;
    logic        match_pulse;
    logic        zero_pulse;
    logic        zero_flag;
    logic        zero_irq;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    last_zero = -1;
    int    last_match = -100;
    int    maxc = 0;
    int    nmatch = 0;
    bit    chk_mz = 1'b0;
    int    per_q[$];
    string tag_q[$];

    always #10 clk = ~clk;  // 50 MHz

    shadow_cmp_timer u_shadow_cmp_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (count_en),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .count      (count),
        .cmp_active (cmp_active),
        .count_down (count_down),
        .match_pulse(match_pulse),
        .zero_pulse (zero_pulse),
        .zero_flag  (zero_flag),
        .zero_irq   (zero_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_per(input int p, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            per_q.push_back(p);
            tag_q.push_back(t);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        count_en = 1'b0;
        chk_mz   = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n     = 1'b1;
        last_zero = -1;
    endtask

    task automatic run_until_drained();
        @(negedge clk);
        count_en = 1'b1;
        while (per_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: measure periods between zero pulses and score them.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (int'(count) > maxc) maxc = int'(count);
            if (match_pulse) begin
                nmatch++;
                last_match = cyc;
            end
            if (zero_pulse) begin
                if (chk_mz) chk("R10 match-to-zero spacing", cyc - last_match, 1);
                if (last_zero >= 0 && per_q.size() > 0) begin
                    chk(tag_q.pop_front(), cyc - last_zero, per_q.pop_front());
                end
                last_zero = cyc;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all reqs: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", int'(count), 0);
        chk("R1 cmp_active", int'(cmp_active), 0);
        chk("R1 flags", int'({count_down, match_pulse, zero_pulse, zero_flag, zero_irq}), 0);

        // Sawtooth, V=9: period 10
        wr(2'd0, 8'd9);
        wr(2'd2, 8'b0010);
        expect_per(10, "R4 sawtooth period", 3);
        last_zero = -1;
        run_until_drained();
        chk("R6 loaded at zero", int'(cmp_active), 9);
        chk_mz = 1'b1;

        // Mid-period buffer write: old period finishes, new one after zero
        do @(negedge clk); while (!zero_pulse);
        #1;
        expect_per(10, "R6 old period kept", 1);
        expect_per(5, "R6 new period", 2);
        wr(2'd0, 8'd4);
        chk("R6 buffer write isolated", int'(cmp_active), 9);
        while (per_q.size() != 0) @(negedge clk);
        chk("R6 active after zero", int'(cmp_active), 4);

        // Strobe gating, then flag clear
        @(negedge clk);
        count_en = 1'b0;
        @(negedge clk);
        c = int'(count);
        repeat (5) @(negedge clk);
        chk("R3 count holds without strobe", int'(count), c);
        chk("R11 flag set", int'(zero_flag), 1);
        chk("R11 irq unmasked", int'(zero_irq), 1);
        wr(2'd3, 8'h01);
        chk("R11 write-1 clears flag", int'(zero_flag), 0);
        chk_mz = 1'b0;

        // Triangle, V=6: period 12, peak 6
        do_reset();
        wr(2'd0, 8'd6);
        wr(2'd2, 8'b0011);
        maxc = 0;
        expect_per(12, "R5 triangle period", 3);
        run_until_drained();
        chk("R5 triangle peak", maxc, 6);

        // Triangle, V=1: period 2
        do_reset();
        wr(2'd0, 8'd1);
        wr(2'd2, 8'b0011);
        nmatch = 0;
        expect_per(2, "R5 triangle V=1 period", 3);
        run_until_drained();
        chk("R10 match pulses seen", (nmatch > 0) ? 1 : 0, 1);

        // Upper field: hi write 0xC1 keeps 6 bits -> V=0x105=261
        do_reset();
        wr(2'd0, 8'h05);
        wr(2'd1, 8'hC1);
        wr(2'd2, 8'b0010);
        expect_per(262, "R2 upper field period", 2);
        run_until_drained();
        chk("R2 upper field value", int'(cmp_active), 261);

        // Zero compare value: free-running wrap
        do_reset();
        wr(2'd0, 8'd0);
        wr(2'd2, 8'b0010);
        nmatch = 0;
        expect_per(16384, "R9 full-range wrap", 2);
        run_until_drained();
        chk("R9 no match at zero cmp", nmatch, 0);

        // Transfer disabled
        do_reset();
        wr(2'd0, 8'd5);
        wr(2'd2, 8'b0000);
        @(negedge clk);
        count_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R7 no copy when disabled", int'(cmp_active), 0);

        // Masked, copy not allowed
        do_reset();
        wr(2'd0, 8'd5);
        wr(2'd2, 8'b0110);
        @(negedge clk);
        count_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R8 masked copy blocked", int'(cmp_active), 0);
        chk("R11 flag set while masked", int'(zero_flag), 1);
        chk("R11 irq gated by mask", int'(zero_irq), 0);

        // Masked, copy allowed
        do_reset();
        wr(2'd0, 8'd5);
        wr(2'd2, 8'b1110);
        @(negedge clk);
        count_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R8 masked copy allowed", int'(cmp_active), 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule